// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the most recent resolved outcomes and a table of 2-bit saturating counters. A lookup XORs the word-aligned bits of the branch address with that history. The result selects one counter, and the counter's upper bit is the guess. The lookup is purely combinational. It returns both the guess and the table index it used.

The fetch side holds the returned index alongside the branch. When the branch resolves, the execute side sends back the real outcome together with that saved index. At the next clock edge the selected counter moves one step toward the outcome, and the outcome enters the history at its low end. The lookup hash can drift between prediction and resolution, but because the update carries the original index, training always lands on the counter that made the prediction.

Top module: `gshare_dir_pred`

## Requirements
- R1: After reset the history is all zeros and every counter holds 00, so any lookup predicts not taken and returns index `lk_pc[9:2]` (default sizes).
- R2: The lookup index is `lk_pc[HIST_W+1:2]` XOR the history; PC bits 1:0 have no effect on index or prediction.
- R3: The prediction is taken (1) exactly when the selected counter is 10 or 11, and not taken (0) when it is 00 or 01.
- R4: An update with outcome taken (`up_taken`=1) adds one to the counter at `up_idx`, saturating at 11, so after three or more taken updates a single not-taken update still leaves the prediction taken.
- R5: An update with outcome not taken (`up_taken`=0) subtracts one from the counter at `up_idx`, saturating at 00, so after three or more not-taken updates a single taken update still leaves the prediction not taken.
- R6: Each update shifts its outcome into history bit 0 (taken as 1), moves older bits up by one, and drops bit HIST_W-1.
- R7: The counter that is trained is the one named by `up_idx`, whatever the history has become since the lookup.
- R8: A lookup in the same cycle as an update to the same counter returns the counter's old value; the new value is visible from the next clock edge.
- R9: With `up_valid` low, `up_idx` and `up_taken` change neither the history nor any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being predicted |
| lk_idx | output | HIST_W | Table index used by this lookup |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Apply a resolved outcome this cycle |
| up_idx | input | HIST_W | Index saved from the branch's lookup |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench drives each counter into both rails and then one step back. A counter that wraps instead of saturating, or one that flips after a single opposing outcome, shows the wrong direction on the following lookup. Lookups and updates to the same counter are issued in the same cycle to catch a write-through read that leaks the new value early. The bench also changes the history between lookup and update to catch a design that retrains the currently hashed entry instead of `up_idx`. Idle cycles with `up_idx` and `up_taken` wiggling, a long pseudo-random mix of both ports, and pairs of addresses that differ only in their offset bits expose any stray history shift, a wrong shift direction, or offset bits leaking into the hash.

// File: rtl/gshare_dir_pred.sv
module gshare_dir_pred #(
  parameter int HIST_W = 8,
  parameter int PC_W   = 32,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic [HIST_W-1:0] lk_idx,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [HIST_W-1:0] up_idx,
  input  logic              up_taken
);
  localparam int ENTRIES = 1 << HIST_W;

  logic [HIST_W-1:0] hist_q;
  logic [1:0]        ctr_q [ENTRIES];
  logic [1:0]        ctr_cur, ctr_nxt;

  assign lk_idx   = lk_pc[HIST_W+OFS_W-1:OFS_W] ^ hist_q;
  assign lk_taken = ctr_q[lk_idx][1];
  assign ctr_cur  = ctr_q[up_idx];

  always_comb begin
    ctr_nxt = ctr_cur;
    if (up_taken && ctr_cur != 2'b11) ctr_nxt = ctr_cur + 2'd1;
    else if (!up_taken && ctr_cur != 2'b00) ctr_nxt = ctr_cur - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'b00;
    end else if (up_valid) begin
      hist_q         <= {hist_q[HIST_W-2:0], up_taken};
      ctr_q[up_idx]  <= ctr_nxt;
    end
  end
endmodule

module gshare_dir_pred_chk #(
  parameter int HIST_W = 8,
  parameter int PC_W   = 32,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   lk_pc,
  input logic [HIST_W-1:0] lk_idx,
  input logic              lk_taken,
  input logic              up_valid,
  input logic [HIST_W-1:0] up_idx,
  input logic              up_taken
);
  logic [HIST_W-1:0] shadow_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_hist <= '0;
    else if (up_valid) shadow_hist <= {shadow_hist[HIST_W-2:0], up_taken};
  end

  // R2 R6
  idx_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_idx == (lk_pc[HIST_W+OFS_W-1:OFS_W] ^ shadow_hist));

  // R4
  taken_keeps_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid && up_taken && lk_taken && (lk_idx == up_idx)) && lk_idx == $past(lk_idx))
      |-> lk_taken);

  // R5
  nt_keeps_nt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid && !up_taken && !lk_taken && (lk_idx == up_idx)) && lk_idx == $past(lk_idx))
      |-> !lk_taken);

  // R9
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(up_valid) && $stable(lk_pc)) |-> ($stable(lk_taken) && $stable(lk_idx)));
endmodule

bind gshare_dir_pred gshare_dir_pred_chk #(.HIST_W(HIST_W), .PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_idx(lk_idx), .lk_taken(lk_taken),
  .up_valid(up_valid), .up_idx(up_idx), .up_taken(up_taken)
);

// File: tb/gshare_dir_pred_bench.sv
module gshare_dir_pred_bench;
  localparam int N = 8;
  localparam int ENT = 1 << N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   lk_pc = '0;
  logic [N-1:0]  lk_idx;
  logic          lk_taken;
  logic          up_valid = 1'b0;
  logic [N-1:0]  up_idx = '0;
  logic          up_taken = 1'b0;

  always #4 clk = ~clk;

  gshare_dir_pred #(.HIST_W(N), .PC_W(32), .OFS_W(2)) u_gshare_dir_pred (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_idx(lk_idx), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_idx(up_idx), .up_taken(up_taken)
  );

  logic [1:0]   m_ctr [ENT];
  logic [N-1:0] m_hist;
  logic [N-1:0] q_idx [$];
  logic         q_tk  [$];
  string        q_req [$];
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  function automatic logic [1:0] sat(logic [1:0] c, logic t);
    if (t) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  function automatic logic [31:0] pc_for(logic [N-1:0] idx, logic [1:0] low);
    return {22'd0, idx ^ m_hist, low};
  endfunction

  task automatic step(logic [31:0] pc, bit look, bit doup, logic [N-1:0] ui, logic ut, string req);
    @(posedge clk); #1;
    lk_pc = pc; up_valid = doup; up_idx = ui; up_taken = ut;
    if (look) begin
      q_idx.push_back(pc[N+1:2] ^ m_hist);
      q_tk.push_back(m_ctr[pc[N+1:2] ^ m_hist][1]);
      q_req.push_back(req);
    end
    if (doup) begin
      @(posedge clk);
      m_ctr[ui] = sat(m_ctr[ui], ut);
      m_hist = {m_hist[N-2:0], ut};
      #1 up_valid = 1'b0;
    end
  endtask

  task automatic look(logic [31:0] pc, string req);
    step(pc, 1'b1, 1'b0, '0, 1'b0, req);
  endtask

  task automatic upd(logic [N-1:0] ui, logic ut);
    step(lk_pc, 1'b0, 1'b1, ui, ut, "");
  endtask

  always @(negedge clk) begin
    if (q_idx.size() != 0) begin
      logic [N-1:0] ei;
      logic         et;
      string        er;
      ei = q_idx.pop_front(); et = q_tk.pop_front(); er = q_req.pop_front();
      n_chk++;
      if (lk_idx !== ei || lk_taken !== et) begin
        n_bad++;
        $display("FAIL %s: idx=%0h taken=%0b, expected idx=%0h taken=%0b", er, lk_idx, lk_taken, ei, et);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < ENT; i++) m_ctr[i] = 2'b00;
    m_hist = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    look(32'h1234_5678, "R1");
    look(32'h0000_03FC, "R1");
    // R2 offset bits ignored
    look(32'h0000_0101, "R2");
    look(32'h0000_0102, "R2");

    // R3/R4: two taken -> weakly taken at idx 5
    upd(8'h05, 1'b1);
    look(pc_for(8'h05, 2'b00), "R3");
    upd(8'h05, 1'b1);
    look(pc_for(8'h05, 2'b11), "R3");
    // R4 saturation
    upd(8'h05, 1'b1); upd(8'h05, 1'b1); upd(8'h05, 1'b1);
    upd(8'h05, 1'b0);
    look(pc_for(8'h05, 2'b00), "R4");
    upd(8'h05, 1'b0);
    look(pc_for(8'h05, 2'b00), "R4");
    // R5 saturation at 00
    upd(8'h05, 1'b0); upd(8'h05, 1'b0); upd(8'h05, 1'b0);
    upd(8'h05, 1'b1);
    look(pc_for(8'h05, 2'b00), "R5");

    // R6 history contents visible through index of pc 0
    upd(8'h10, 1'b1); upd(8'h11, 1'b0); upd(8'h12, 1'b1);
    look(32'h0, "R6");

    // R7 index from update port, history changed meanwhile
    look(pc_for(8'h33, 2'b00), "R7");
    upd(8'h00, 1'b1);
    upd(8'h33, 1'b1); upd(8'h33, 1'b1);
    look(pc_for(8'h33, 2'b00), "R7");
    look(pc_for(8'h00, 2'b00), "R7");

    // R8 same-cycle lookup and update of one counter
    upd(8'h44, 1'b1);
    step(pc_for(8'h44, 2'b00), 1'b1, 1'b1, 8'h44, 1'b1, "R8");
    look(pc_for(8'h44, 2'b00), "R8");

    // R9 idle port with live-looking inputs
    look(pc_for(8'h55, 2'b00), "R9");
    @(posedge clk); #1 up_idx = 8'h55; up_taken = 1'b1;
    @(posedge clk); #1 up_idx = 8'h56; up_taken = 1'b0;
    look(pc_for(8'h55, 2'b00), "R9");
    look(32'h0, "R9");

    // R3 mixed pseudo-random traffic
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[0]) upd(lf[8:1] & 8'h0F, lf[9] | lf[10]);
      look({20'd0, lf[15:4]}, "R3");
    end

    @(posedge clk); @(negedge clk); @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule